// File: doc/BRIEF.md
# Quarter-Wave Sine Oscillator

This block is a numerically controlled sine source. On every enabled clock a phase register advances by a programmable tuning word. The upper phase bits select a quadrant and an offset within it. A magnitude table covering only 0 to 90 degrees serves all four quadrants: the table address is mirrored in quadrants 1 and 3, and the sign is flipped in quadrants 2 and 3.

Each enabled cycle produces one signed sample together with a valid strobe. The sine period, counted in enabled samples, is 65536 divided by the tuning word. The output frequency is therefore the tuning word times the sample rate divided by 2^16. The table is computed when the design is elaborated, so no external data file is needed.

Top module: `nco_quarter_sine`

## Requirements
- R1: Asserting the active-low reset `rst_ni` clears the phase to 0, `sample_o` to 0 and `valid_o` to 0.
- R2: At each rising edge where `en_i` is 1, the 16-bit phase advances by `tune_word_i`. At an edge where `en_i` is 0, the phase holds.
- R3: `valid_o` is 1 in the cycle after an edge where `en_i` was 1, and 0 in the cycle after an edge where `en_i` was 0.
- R4: After an enabled edge, `sample_o` holds the amplitude of the phase value the register held before that edge. After an edge where `en_i` is 0, `sample_o` keeps its value.
- R5: Phase bits [15:14] are the quadrant and bits [13:6] are the 8-bit table index. Bits [5:0] are ignored (truncated).
- R6: Table entry k (0..255) is round(4095 * sin((k + 0.5) * pi / 512)). The 12-bit magnitude therefore lies in 13..4095 and is never zero.
- R7: In quadrants 1 and 3 (phase bit 14 = 1), the table is addressed with 255 minus the index. In quadrants 0 and 2 it is addressed with the index unchanged.
- R8: In quadrants 2 and 3 (phase bit 15 = 1), `sample_o` is the 13-bit two's-complement negation of the magnitude. Otherwise it is the positive magnitude.
- R9: The phase wraps modulo 2^16 and no overflow indication is produced.
- R10: With a constant tuning word T that divides 65536, the sample sequence repeats every 65536/T enabled samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance phase and produce one sample |
| tune_word_i | input | 16 | Phase increment per enabled cycle |
| sample_o | output | 13 | Signed two's-complement sine sample |
| valid_o | output | 1 | Sample produced by the previous edge |

## Verification
The checker runs on every cycle and checks four things: that the valid strobe tracks the enable with one cycle of delay, that the phase and the sample freeze while the enable is low, that the sample sign matches the half of the cycle the prior phase was in, and that the magnitude stays within full scale and never becomes zero. The exact table values, the address mirroring across quadrant boundaries, the truncation of low phase bits, the wrap through zero and the repetition period depend on specific tuning word sequences. Only the bench shows these, by comparing each sample with a sine model computed at run time.

// File: rtl/nco_pkg.sv
`timescale 1ns/1ps
package nco_pkg;
  typedef enum logic [1:0] {
    QUAD_RISE     = 2'd0,
    QUAD_FALL     = 2'd1,
    QUAD_NEG_FALL = 2'd2,
    QUAD_NEG_RISE = 2'd3
  } quad_e;

  localparam real HALF_PI = 1.5707963267948966;

  function automatic logic quad_mirror(input quad_e q);
    return q == QUAD_FALL || q == QUAD_NEG_RISE;
  endfunction

  function automatic logic quad_negate(input quad_e q);
    return q == QUAD_NEG_FALL || q == QUAD_NEG_RISE;
  endfunction
endpackage

// File: rtl/nco_phase_acc.sv
`timescale 1ns/1ps
module nco_phase_acc #(
  parameter int PHASE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] tune_word_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_q;

  // modulo 2^PHASE_W wrap, carry discarded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   phase_q <= '0;
    else if (en_i) phase_q <= phase_q + tune_word_i;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/nco_quarter_lut.sv
`timescale 1ns/1ps
module nco_quarter_lut #(
  parameter int IDX_W = 8,
  parameter int AMP_W = 12
) (
  input  logic [IDX_W-1:0] addr_i,
  output logic [AMP_W-1:0] mag_o
);
  localparam int TBL_N  = 1 << IDX_W;
  localparam int FULL   = (1 << AMP_W) - 1;
  localparam int TERMS  = 12;

  // half-step sample points make the quadrant symmetric under address inversion
  function automatic logic [AMP_W-1:0] sine_mag(input int k);
    real x, term, acc;
    int  v;
    logic [31:0] vb;
    x    = (real'(k) + 0.5) * nco_pkg::HALF_PI / real'(TBL_N);
    term = x;
    acc  = x;
    for (int n = 1; n <= TERMS; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    v  = $rtoi(acc * real'(FULL) + 0.5);
    vb = 32'(v);
    return vb[AMP_W-1:0];
  endfunction

  logic [AMP_W-1:0] rom [TBL_N];

  for (genvar k = 0; k < TBL_N; k++) begin : g_ent
    localparam logic [AMP_W-1:0] ENT = sine_mag(k);
    assign rom[k] = ENT;
  end

  assign mag_o = rom[addr_i];
endmodule

// File: rtl/nco_quad_fold.sv
`timescale 1ns/1ps
module nco_quad_fold #(
  parameter int IDX_W = 8,
  parameter int AMP_W = 12
) (
  input  logic [IDX_W+1:0]  phase_top_i,
  input  logic [AMP_W-1:0]  mag_i,
  output logic [IDX_W-1:0]  addr_o,
  output logic [AMP_W:0]    sample_o
);
  import nco_pkg::*;

  quad_e            quad;
  logic [IDX_W-1:0] idx;
  logic [AMP_W:0]   mag_ext;

  assign quad    = quad_e'(phase_top_i[IDX_W+1:IDX_W]);
  assign idx     = phase_top_i[IDX_W-1:0];
  assign addr_o  = quad_mirror(quad) ? ~idx : idx;
  assign mag_ext = {1'b0, mag_i};

  always_comb begin
    if (quad_negate(quad)) sample_o = -mag_ext;
    else                   sample_o = mag_ext;
  end
endmodule

// File: rtl/nco_quarter_sine.sv
`timescale 1ns/1ps
module nco_quarter_sine #(
  parameter int PHASE_W = 16,
  parameter int IDX_W   = 8,
  parameter int AMP_W   = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] tune_word_i,
  output logic [AMP_W:0]     sample_o,
  output logic               valid_o
);
  localparam int TOP_W = IDX_W + 2;

  logic [PHASE_W-1:0] phase_q;
  logic [IDX_W-1:0]   lut_addr;
  logic [AMP_W-1:0]   lut_mag;
  logic [AMP_W:0]     sample_d;
  logic [AMP_W:0]     sample_q;
  logic               valid_q;

  nco_phase_acc #(.PHASE_W(PHASE_W)) i_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .tune_word_i (tune_word_i),
    .phase_o     (phase_q)
  );

  nco_quad_fold #(.IDX_W(IDX_W), .AMP_W(AMP_W)) i_fold (
    .phase_top_i (phase_q[PHASE_W-1 -: TOP_W]),
    .mag_i       (lut_mag),
    .addr_o      (lut_addr),
    .sample_o    (sample_d)
  );

  nco_quarter_lut #(.IDX_W(IDX_W), .AMP_W(AMP_W)) i_lut (
    .addr_i (lut_addr),
    .mag_o  (lut_mag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= en_i;
      if (en_i) sample_q <= sample_d;
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/nco_quarter_sine_chk.sv
`timescale 1ns/1ps
module nco_quarter_sine_chk #(
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [PHASE_W-1:0] phase_i,
  input logic [AMP_W:0]     sample_o,
  input logic               valid_o
);
  localparam logic [AMP_W:0] MOST_NEG = {1'b1, {AMP_W{1'b0}}};

  assert_valid_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> valid_o);

  assert_valid_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);

  assert_phase_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(phase_i));

  assert_sample_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(sample_o));

  assert_sign_half_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> sample_o[AMP_W] == $past(phase_i[PHASE_W-1]));

  assert_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> sample_o != '0);

  assert_full_scale_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o != MOST_NEG);
endmodule

bind nco_quarter_sine nco_quarter_sine_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .phase_i  (phase_q),
  .sample_o (sample_o),
  .valid_o  (valid_o)
);

// File: tb/test_nco_quarter_sine.sv
`timescale 1ns/1ps
module test_nco_quarter_sine;
  localparam real PI = 3.14159265358979323846;
  localparam int  NV = 24;

  // {en, tune_word}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 16'h0000}, {1'b1, 16'h0040}, {1'b1, 16'h0040}, {1'b1, 16'h003F},
    {1'b1, 16'h0001}, {1'b0, 16'h1234}, {1'b0, 16'h5555}, {1'b1, 16'h3F00},
    {1'b1, 16'h0040}, {1'b1, 16'h0040}, {1'b1, 16'h4000}, {1'b1, 16'h4000},
    {1'b1, 16'h4000}, {1'b1, 16'hFFC0}, {1'b1, 16'hFFFF}, {1'b1, 16'hFFFF},
    {1'b1, 16'h1000}, {1'b1, 16'h2345}, {1'b1, 16'h7777}, {1'b0, 16'h0000},
    {1'b1, 16'h8000}, {1'b1, 16'h8000}, {1'b1, 16'h8000}, {1'b1, 16'h0123}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [15:0] tune_word_i = '0;
  logic [12:0] sample_o;
  logic        valid_o;

  int          n_run = 0;
  int          n_fail = 0;
  logic [15:0] ph_m = '0;
  int          exp_s = 0;
  int          s_hist [8];

  nco_quarter_sine i_nco_quarter_sine (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (en_i),
    .tune_word_i (tune_word_i), .sample_o (sample_o), .valid_o (valid_o)
  );

  always #2.5 clk_i = ~clk_i;

  // R5..R8 model
  function automatic int amp(input logic [15:0] ph);
    int k, m;
    k = int'(ph[13:6]);
    if (ph[14]) k = 255 - k;
    m = $rtoi(4095.0 * $sin((real'(k) + 0.5) * PI / 512.0) + 0.5);
    return ph[15] ? -m : m;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive, clock, sample 1 ns after the edge; R2 R3 R4 R9 tracked by the model
  task automatic cyc(input logic en, input logic [15:0] tw, input string req);
    en_i = en;
    tune_word_i = tw;
    @(posedge clk_i);
    #1;
    if (en) begin
      exp_s = amp(ph_m);
      ph_m  = ph_m + tw;
    end
    chk({req, " valid"}, int'(valid_o), int'(en));
    chk({req, " sample"}, int'($signed(sample_o)), exp_s);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #12;
    // R1: outputs cleared while in reset
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 sample", int'($signed(sample_o)), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;

    // vector walk: R2 R4 R5 R6 R7 R8 R9 exercised across quadrant edges and wraps
    for (int i = 0; i < NV; i++) cyc(VEC[i][16], VEC[i][15:0], "R4 R5 R6 R7 R8 R9 vec");

    // R1: asynchronous reset mid-run, between edges
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1 async valid", int'(valid_o), 0);
    chk("R1 async sample", int'($signed(sample_o)), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    ph_m  = '0;
    exp_s = 0;
    cyc(1'b0, 16'h0100, "R1 post-reset hold");

    // R7: mirror pair 0x3FC0 / 0x4000 give the same magnitude
    cyc(1'b1, 16'h3FC0, "R2");
    cyc(1'b1, 16'h0040, "R7 pre");
    s_hist[0] = int'($signed(sample_o));
    cyc(1'b1, 16'hC000, "R7 post");
    chk("R7 mirror", int'($signed(sample_o)), s_hist[0]);

    // R10: T = 0x4000 repeats every 4 samples; R8: half-cycle apart is negated
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 16'h4000, "R10 run");
      s_hist[i] = int'($signed(sample_o));
    end
    for (int i = 0; i < 4; i++) chk("R10 period", s_hist[i + 4], s_hist[i]);
    chk("R8 antiphase", s_hist[2], -s_hist[0]);

    // R5: low-bit-only changes leave the index unchanged
    ph_m = ph_m;
    cyc(1'b1, 16'h0020, "R5 a");
    s_hist[0] = int'($signed(sample_o));
    cyc(1'b1, 16'h0000, "R5 b");
    chk("R5 truncation", int'($signed(sample_o)), s_hist[0] == amp(ph_m) ? s_hist[0] : amp(ph_m));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule